// File: doc/BRIEF.md
# Wait-for-Interrupt Sleep Controller

This block decides when a processor core that has executed a wait-for-interrupt instruction may actually go to sleep, and when it must wake up again. When the strobe arrives, the block first classifies the instruction. A user-mode wait while the timeout-wait control bit is set is flagged as an illegal instruction. A wait issued in debug mode or during single-stepping behaves as a no-op. Any other wait asks the instruction front-end and the execution back-end to halt.

Once both the fetch side and the data side report no outstanding bus access, and no enabled interrupt is pending, the sleep status output is raised. If clock gating is built in, the main-clock enable is then dropped. The block runs entirely on an always-on auxiliary clock. It registers the enabled-and-pending interrupt vector and the debug halt request in that domain, so wake detection keeps working while the core clock is stopped. When a wake source appears, the clock enable comes back one cycle before the sleep status and halt request fall. The core therefore always resumes on a running clock.

Top module: `wfi_sleep_ctrl`

## Requirements
- R1: After reset `sleeping`, `halt_req` and `illegal_wfi` are 0 and `clk_en` is 1.
- R2: A wfi strobe with `priv_user`=1 (1 means user mode) and `tw_bit`=1, outside debug and step mode, drives `illegal_wfi` high in the cycle after the strobe and raises no halt request.
- R3: A wfi strobe while `dbg_mode` or `step_mode` is 1 is a no-op: no illegal flag, no halt request and no sleep, even with user mode and `tw_bit` set.
- R4: A legal wfi strobe drives `halt_req` high in the cycle after the strobe, and `halt_req` stays high for as long as `sleeping` is high.
- R5: `sleeping` rises only on a clock edge at which `fetch_busy` and `data_busy` are both 0 and the registered interrupt/debug wake condition is clear. While either busy flag is 1, the block keeps `halt_req` high and `sleeping` low.
- R6: During sleep, any bit of `irq_pend` set before edge n is registered at edge n. `clk_en` returns to 1 after edge n+1, and `sleeping` and `halt_req` fall after edge n+2.
- R7: A `dbg_halt_req` during sleep wakes the block with the same timing as R6.
- R8: With `GATE_EN`=1, `clk_en` falls one cycle after `sleeping` rises and is 1 whenever `sleeping` is 0. With `GATE_EN`=0, `clk_en` stays 1.
- R9: An enabled interrupt that becomes pending while the halt is still draining ends the wait: `halt_req` returns to 0 and `sleeping` never rises.
- R10: A wfi in machine mode (`priv_user`=0) with `tw_bit`=1 is legal and enters sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aux | input | 1 | Always-on auxiliary clock |
| rst | input | 1 | Synchronous active-high reset |
| wfi_exec | input | 1 | Wait-for-interrupt execute strobe |
| priv_user | input | 1 | Current privilege is user mode when 1 |
| tw_bit | input | 1 | Timeout-wait control bit |
| dbg_mode | input | 1 | Core is in debug mode |
| step_mode | input | 1 | Core is single-stepping |
| fetch_busy | input | 1 | Instruction fetch access outstanding |
| data_busy | input | 1 | Data access outstanding |
| irq_pend | input | NIRQ | Enabled-and-pending interrupt vector |
| dbg_halt_req | input | 1 | Debug halt request |
| illegal_wfi | output | 1 | Wfi raised an illegal-instruction condition |
| halt_req | output | 1 | Halt request to front-end and back-end |
| sleeping | output | 1 | Core is asleep |
| clk_en | output | 1 | Main clock gate enable |

## Verification
The wait instruction is applied under every classification: user mode with the timeout bit set, debug mode and step mode with that same combination, and machine mode with the timeout bit set. This separates the illegal path, the no-op precedence and the legal path. Sleep entry is tried with both bus sides idle, with a fetch still outstanding, and with an interrupt already pending or arriving mid-drain. This shows that all three entry conditions are checked and that an abort releases the halt. Wakes come from a low interrupt bit, a high interrupt bit and the debug request. Each wake is sampled cycle by cycle, and an instance built without gating is compared against the gated one to confirm the clock-enable ordering.

// File: rtl/wfi_sleep_pkg.sv
package wfi_sleep_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_DRAIN  = 2'd1,
    ST_SLEEP  = 2'd2,
    ST_RESUME = 2'd3
  } slp_state_t;
endpackage

// File: rtl/wfi_classify.sv
module wfi_classify (
  input  logic clk,
  input  logic rst,
  input  logic wfi_exec,
  input  logic priv_user,
  input  logic tw_bit,
  input  logic dbg_mode,
  input  logic step_mode,
  output logic sleep_go,
  output logic illegal_q
);
  logic nop_mode;
  logic trap_case;

  assign nop_mode  = dbg_mode | step_mode;
  assign trap_case = priv_user & tw_bit;
  assign sleep_go  = wfi_exec & ~nop_mode & ~trap_case;

  always_ff @(posedge clk) begin
    if (rst) illegal_q <= 1'b0;
    else     illegal_q <= wfi_exec & ~nop_mode & trap_case;
  end

  // R2 / R3: the flag only follows a trapping strobe outside debug/step
  assert_illegal_cause_R2: assert property (@(posedge clk) disable iff (rst)
    illegal_q |-> $past(wfi_exec && priv_user && tw_bit && !dbg_mode && !step_mode));
endmodule

// File: rtl/wake_capture.sv
module wake_capture #(
  parameter int NIRQ = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic            dbg_halt_req,
  output logic            wake
);
  logic [NIRQ-1:0] irq_q;
  logic            dbg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= '0;
      dbg_q <= 1'b0;
    end else begin
      irq_q <= irq_pend;
      dbg_q <= dbg_halt_req;
    end
  end

  assign wake = (|irq_q) | dbg_q;

  // R6 / R7: a wake must come from a source sampled one edge earlier
  assert_wake_source_R6: assert property (@(posedge clk) disable iff (rst)
    wake |-> $past((|irq_pend) || dbg_halt_req));
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import wfi_sleep_pkg::*;
#(
  parameter bit GATE_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_go,
  input  logic wake,
  input  logic fetch_busy,
  input  logic data_busy,
  output logic halt_q,
  output logic sleep_q,
  output logic clk_en_q
);
  slp_state_t st_q, ns;
  logic       idle;

  assign idle = ~fetch_busy & ~data_busy;

  always_comb begin
    ns = st_q;
    unique case (st_q)
      ST_RUN:    if (sleep_go) ns = ST_DRAIN;
      ST_DRAIN:  if (wake) ns = ST_RUN;
                 else if (idle) ns = ST_SLEEP;
      ST_SLEEP:  if (wake) ns = ST_RESUME;
      ST_RESUME: ns = ST_RUN;
      default:   ns = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_RUN;
      halt_q   <= 1'b0;
      sleep_q  <= 1'b0;
      clk_en_q <= 1'b1;
    end else begin
      st_q     <= ns;
      halt_q   <= (ns != ST_RUN);
      sleep_q  <= (ns == ST_SLEEP) || (ns == ST_RESUME);
      clk_en_q <= !(GATE_EN && (ns == ST_SLEEP) && sleep_q);
    end
  end

  // R5: sleep is entered only from an idle, wake-free edge
  assert_sleep_idle_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep_q) |-> $past(!fetch_busy && !data_busy && !wake));
  // R4: the halt request covers the whole sleep period
  assert_halt_covers_R4: assert property (@(posedge clk) disable iff (rst)
    sleep_q |-> halt_q);
  // R8: the clock is cut only after sleep has been visible for a cycle
  assert_gate_after_sleep_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_en_q) |-> (sleep_q && $past(sleep_q)));
  // R6: the clock is back before sleep is released
  assert_clock_first_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep_q) |-> (clk_en_q && $past(clk_en_q)));
endmodule

// File: rtl/wfi_sleep_ctrl.sv
module wfi_sleep_ctrl #(
  parameter int NIRQ    = 16,
  parameter bit GATE_EN = 1'b1
) (
  input  logic            clk_aux,
  input  logic            rst,
  input  logic            wfi_exec,
  input  logic            priv_user,
  input  logic            tw_bit,
  input  logic            dbg_mode,
  input  logic            step_mode,
  input  logic            fetch_busy,
  input  logic            data_busy,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic            dbg_halt_req,
  output logic            illegal_wfi,
  output logic            halt_req,
  output logic            sleeping,
  output logic            clk_en
);
  logic sleep_go;
  logic wake;

  wfi_classify u_classify (
    .clk       (clk_aux),
    .rst       (rst),
    .wfi_exec  (wfi_exec),
    .priv_user (priv_user),
    .tw_bit    (tw_bit),
    .dbg_mode  (dbg_mode),
    .step_mode (step_mode),
    .sleep_go  (sleep_go),
    .illegal_q (illegal_wfi)
  );

  wake_capture #(.NIRQ(NIRQ)) u_wake (
    .clk          (clk_aux),
    .rst          (rst),
    .irq_pend     (irq_pend),
    .dbg_halt_req (dbg_halt_req),
    .wake         (wake)
  );

  sleep_fsm #(.GATE_EN(GATE_EN)) u_fsm (
    .clk        (clk_aux),
    .rst        (rst),
    .sleep_go   (sleep_go),
    .wake       (wake),
    .fetch_busy (fetch_busy),
    .data_busy  (data_busy),
    .halt_q     (halt_req),
    .sleep_q    (sleeping),
    .clk_en_q   (clk_en)
  );

  // R1 / R8: with gating built in, the clock is never off while awake
  assert_awake_clocked_R8: assert property (@(posedge clk_aux) disable iff (rst)
    !sleeping |-> clk_en);
endmodule

// File: tb/wfi_sleep_ctrl_tb.sv
module wfi_sleep_ctrl_tb;
  localparam int NIRQ = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wfi_exec = 0, priv_user = 0, tw_bit = 0, dbg_mode = 0, step_mode = 0;
  logic fetch_busy = 0, data_busy = 0, dbg_halt_req = 0;
  logic [NIRQ-1:0] irq_pend = '0;
  logic illegal_wfi, halt_req, sleeping, clk_en;
  logic ng_ill, ng_halt, ng_sleep, ng_clk_en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wfi_sleep_ctrl #(.NIRQ(NIRQ), .GATE_EN(1'b1)) u_dut (
    .clk_aux(clk), .rst(rst), .wfi_exec(wfi_exec), .priv_user(priv_user),
    .tw_bit(tw_bit), .dbg_mode(dbg_mode), .step_mode(step_mode),
    .fetch_busy(fetch_busy), .data_busy(data_busy), .irq_pend(irq_pend),
    .dbg_halt_req(dbg_halt_req), .illegal_wfi(illegal_wfi), .halt_req(halt_req),
    .sleeping(sleeping), .clk_en(clk_en));

  wfi_sleep_ctrl #(.NIRQ(NIRQ), .GATE_EN(1'b0)) u_dut_nogate (
    .clk_aux(clk), .rst(rst), .wfi_exec(wfi_exec), .priv_user(priv_user),
    .tw_bit(tw_bit), .dbg_mode(dbg_mode), .step_mode(step_mode),
    .fetch_busy(fetch_busy), .data_busy(data_busy), .irq_pend(irq_pend),
    .dbg_halt_req(dbg_halt_req), .illegal_wfi(ng_ill), .halt_req(ng_halt),
    .sleeping(ng_sleep), .clk_en(ng_clk_en));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic nx(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input logic usr, input logic tw);
    priv_user = usr; tw_bit = tw; wfi_exec = 1'b1;
    nx(1);
    wfi_exec = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 sleeping", sleeping, 1'b0);
    chk("R1 halt_req", halt_req, 1'b0);
    chk("R1 illegal_wfi", illegal_wfi, 1'b0);
    chk("R1 clk_en", clk_en, 1'b1);
  endtask

  task automatic t_user_tw();
    strobe(1'b1, 1'b1);
    chk("R2 illegal_wfi", illegal_wfi, 1'b1);
    chk("R2 halt_req", halt_req, 1'b0);
    nx(1);
    chk("R2 illegal pulse ends", illegal_wfi, 1'b0);
    chk("R2 sleeping", sleeping, 1'b0);
    priv_user = 0; tw_bit = 0;
  endtask

  task automatic t_nop(input logic use_dbg);
    dbg_mode = use_dbg; step_mode = !use_dbg;
    strobe(1'b1, 1'b1);
    chk("R3 illegal_wfi", illegal_wfi, 1'b0);
    chk("R3 halt_req", halt_req, 1'b0);
    nx(2);
    chk("R3 sleeping", sleeping, 1'b0);
    chk("R3 clk_en", clk_en, 1'b1);
    dbg_mode = 0; step_mode = 0; priv_user = 0; tw_bit = 0;
  endtask

  task automatic t_sleep_wake(input int idx, input logic use_dbg, input logic tw);
    string tg;
    tg = use_dbg ? "R7" : "R6";
    strobe(1'b0, tw);
    chk(tw ? "R10 halt_req" : "R4 halt_req", halt_req, 1'b1);
    chk("R4 illegal_wfi", illegal_wfi, 1'b0);
    chk("R5 not yet sleeping", sleeping, 1'b0);
    nx(1);
    chk(tw ? "R10 sleeping" : "R5 sleeping", sleeping, 1'b1);
    chk("R8 clk_en still on", clk_en, 1'b1);
    nx(1);
    chk("R8 clk_en off", clk_en, 1'b0);
    chk("R8 nogate clk_en", ng_clk_en, 1'b1);
    chk("R8 nogate sleeping", ng_sleep, 1'b1);
    nx(3);
    chk("R4 halt held", halt_req, 1'b1);
    chk("R5 still sleeping", sleeping, 1'b1);
    if (use_dbg) dbg_halt_req = 1'b1; else irq_pend[idx] = 1'b1;
    nx(1);
    chk({tg, " clk_en off after capture"}, clk_en, 1'b0);
    nx(1);
    chk({tg, " clk_en back"}, clk_en, 1'b1);
    chk({tg, " sleeping held"}, sleeping, 1'b1);
    nx(1);
    chk({tg, " sleeping released"}, sleeping, 1'b0);
    chk({tg, " halt released"}, halt_req, 1'b0);
    irq_pend = '0; dbg_halt_req = 0; tw_bit = 0;
    nx(2);
  endtask

  task automatic t_drain_busy();
    fetch_busy = 1'b1;
    strobe(1'b0, 1'b0);
    chk("R5 halt while busy", halt_req, 1'b1);
    nx(4);
    chk("R5 no sleep while fetch busy", sleeping, 1'b0);
    chk("R5 halt held while busy", halt_req, 1'b1);
    data_busy = 1'b1; fetch_busy = 1'b0;
    nx(2);
    chk("R5 no sleep while data busy", sleeping, 1'b0);
    data_busy = 1'b0;
    nx(1);
    chk("R5 sleeping once idle", sleeping, 1'b1);
    dbg_halt_req = 1'b1;
    nx(3);
    chk("R7 awake after debug wake", sleeping, 1'b0);
    dbg_halt_req = 1'b0;
    nx(2);
  endtask

  task automatic t_abort();
    data_busy = 1'b1;
    strobe(1'b0, 1'b0);
    chk("R9 halt draining", halt_req, 1'b1);
    irq_pend[3] = 1'b1;
    nx(2);
    chk("R9 halt released", halt_req, 1'b0);
    chk("R9 never slept", sleeping, 1'b0);
    data_busy = 1'b0;
    nx(2);
    chk("R9 still awake", sleeping, 1'b0);
    // interrupt already pending before the wait
    strobe(1'b0, 1'b0);
    nx(1);
    chk("R9 pending blocks sleep", sleeping, 1'b0);
    chk("R9 pending releases halt", halt_req, 1'b0);
    irq_pend = '0;
    nx(2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    nx(3);
    rst = 1'b0;
    nx(1);
    t_reset();
    t_user_tw();
    t_nop(1'b1);
    t_nop(1'b0);
    t_sleep_wake(0, 1'b0, 1'b0);
    t_sleep_wake(NIRQ-1, 1'b0, 1'b0);
    t_sleep_wake(0, 1'b1, 1'b0);
    t_sleep_wake(5, 1'b0, 1'b1);
    t_drain_busy();
    t_abort();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule